// File: doc/BRIEF.md
# MDIO management frame master

This block runs single management transactions on a two-wire PHY management bus. It divides the system clock down to the management clock (MDC). It drives the shared data line (MDIO) through an output value and an output enable, and it samples the line back through a separate input. The user raises a one-cycle start strobe together with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then sends the whole frame: a preamble of ones, the start and opcode fields, both addresses, the turnaround and the data phase.

On a read, the block lets go of the line during turnaround and checks that the PHY pulls it low. If the PHY does not, the block sends a burst of 32 idle MDC cycles to resynchronise the PHY and ends with the error flag set. Otherwise it shifts in 16 data bits and adds two trailing clocks. Each transaction ends with a one-cycle done pulse. Between transactions MDC rests high and the line is released.

Top module: `mdio_frame_master`

## Requirements
- R1: Between transactions, and in the done cycle, mdc_o is 1 and mdio_oe_o is 0. A new frame starts only on an accepted start strobe.
- R2: Every frame opens with 32 MDC cycles in which mdio_oe_o=1 and mdio_o=1.
- R3: The preamble is followed by the start field 0,1 and then the opcode. The opcode is 1,0 when rd_nwr_i=1 (read) and 0,1 when rd_nwr_i=0 (write).
- R4: After the opcode come phy_addr_i as 5 bits, MSB first, and then reg_addr_i as 5 bits, MSB first.
- R5: mdio_o and mdio_oe_o change only while MDC is low, so each bit is stable at the MDC rising edge. Each MDC half period lasts exactly HALF_CYCLES system clocks.
- R6: On a write, the block drives turnaround 1,0. It then drives wr_data_i as 16 bits, MSB first, and finally releases the line for one more MDC cycle. The frame has 65 MDC cycles.
- R7: On a read, the line is released from the turnaround slot to the end of the frame. If the line is 0 at the end of the turnaround slot, 16 bits are captured MSB first, each sampled near the end of the MDC high half. Two trailing MDC cycles follow (65 in all). rd_data_o then shows the value, and done_o is raised with err_o=0.
- R8: If the line is 1 at the end of the read turnaround slot, the block issues 32 more MDC cycles (79 in all) with the line released. It then raises done_o with err_o=1 and leaves rd_data_o unchanged.
- R9: A start strobe while a transaction is in progress is ignored: the running frame is unchanged and no extra frame or done follows.
- R10: done_o lasts exactly one system clock per transaction. err_o is 1 only in a done cycle.
- R11: While rst_n is sampled low at a clock edge, the block returns to idle (mdc_o=1, mdio_oe_o=0, done_o=0, rd_data_o=0), even mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| rd_nwr_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wr_data_i | input | 16 | Write payload |
| rd_data_o | output | 16 | Last successfully read value |
| done_o | output | 1 | Transaction complete pulse |
| err_o | output | 1 | Turnaround failure, valid with done_o |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Line value when driven |
| mdio_oe_o | output | 1 | Line output enable |
| mdio_i | input | 1 | Line value as seen on the bus |

## Verification
The bench decodes every bit at the MDC rising edges and goes after the corner cases. In turnaround a PHY that never answers must produce the long recovery frame with the error flag and no change of read data. A design that skipped the check would return all-ones data with no error. All-ones, all-zeros and single-bit patterns at the extreme addresses show whether the data is shifted MSB first without losing a bit. A start strobe in mid-frame and a reset in mid-frame expose a design that relatches its request or fails to drop the line and park MDC high. Half-period lengths are measured throughout, so a divider that is off by one shows up as a timing failure.

// File: rtl/mdio_pkg.sv
// Package: mdio_pkg
// Shared sequencer state type and the fixed field lengths of a
// management frame. Assumes single-register (clause 22 style) frames.
package mdio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_FRAME   = 2'd1,
        ST_RECOVER = 2'd2
    } seq_state_e;

    localparam int START_LEN = 2;  // start field bits
    localparam int OP_LEN    = 2;  // opcode bits
    localparam int TA_LEN    = 2;  // write turnaround bits
    localparam int WR_TAIL   = 1;  // released cycles after write data
    localparam int RD_TAIL   = 2;  // extra cycles after read data

endpackage

// File: rtl/mdc_tick_gen.sv
// Module: mdc_tick_gen
// Emits a one-cycle tick every HALF_CYCLES system clocks while run_i is
// high. Each tick marks the end of one MDC half period. The counter is
// held at zero while idle, so the first half period after a start is
// exactly HALF_CYCLES long. Assumes HALF_CYCLES >= 2.
module mdc_tick_gen #(
    parameter int HALF_CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == CNT_END);

    // Half-period counter: cleared when idle, wraps on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Two ticks never fall on adjacent cycles, so no half period is shortened.
    assert_tick_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/mdio_frame_seq.sv
// Module: mdio_frame_seq
// Walks a frame slot by slot. One slot is one MDC cycle: a low half,
// where the driven bit is updated, and then a high half. Read data and
// the turnaround bit are sampled at the tick that ends the high half.
// Assumes mdio_in_i is already synchronised and that tick_i comes from
// mdc_tick_gen driven by run_o.
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN   = 32,
    parameter int RECOV_LEN = 32,
    parameter int PHY_AW    = 5,
    parameter int REG_AW    = 5,
    parameter int DATA_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic              rd_i,
    input  logic [PHY_AW-1:0] phy_i,
    input  logic [REG_AW-1:0] reg_i,
    input  logic [DATA_W-1:0] wd_i,
    input  logic              mdio_in_i,
    output logic              run_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o,
    output logic              err_o
);
    localparam int S_START = PRE_LEN;
    localparam int S_OP    = S_START + START_LEN;
    localparam int S_PHY   = S_OP + OP_LEN;
    localparam int S_REG   = S_PHY + PHY_AW;
    localparam int S_TA    = S_REG + REG_AW;
    localparam int S_WDAT  = S_TA + TA_LEN;
    localparam int S_RDAT  = S_TA + 1;
    localparam int S_LAST  = S_WDAT + DATA_W + WR_TAIL - 1;
    localparam int S_RLAST = S_TA + RECOV_LEN;
    localparam int S_MAX   = (S_LAST > S_RLAST) ? S_LAST : S_RLAST;
    localparam int SW      = $clog2(S_MAX + 1);

    localparam logic [SW-1:0] L_START = SW'(S_START);
    localparam logic [SW-1:0] L_ST1   = SW'(S_START + 1);
    localparam logic [SW-1:0] L_OP    = SW'(S_OP);
    localparam logic [SW-1:0] L_OP1   = SW'(S_OP + 1);
    localparam logic [SW-1:0] L_PHY   = SW'(S_PHY);
    localparam logic [SW-1:0] L_REG   = SW'(S_REG);
    localparam logic [SW-1:0] L_TA    = SW'(S_TA);
    localparam logic [SW-1:0] L_TA1   = SW'(S_TA + 1);
    localparam logic [SW-1:0] L_WDAT  = SW'(S_WDAT);
    localparam logic [SW-1:0] L_WEND  = SW'(S_WDAT + DATA_W - 1);
    localparam logic [SW-1:0] L_RDAT  = SW'(S_RDAT);
    localparam logic [SW-1:0] L_REND  = SW'(S_RDAT + DATA_W - 1);
    localparam logic [SW-1:0] L_LAST  = SW'(S_LAST);
    localparam logic [SW-1:0] L_RLAST = SW'(S_RLAST);

    seq_state_e        state_q;
    logic [SW-1:0]     slot_q;
    logic              hi_q;
    logic              rd_q;
    logic [PHY_AW-1:0] phy_q;
    logic [REG_AW-1:0] reg_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] rdata_q;
    logic              mdc_q, dq, oe_q, done_q, err_q;

    logic ta_fail, cap_en, end_ok, end_err;

    // Returns {output enable, value} for slot s of a frame.
    function automatic logic [1:0] slot_drive(
        input logic [SW-1:0]     s,
        input logic              rd,
        input logic [PHY_AW-1:0] pa,
        input logic [REG_AW-1:0] ra,
        input logic [DATA_W-1:0] wd
    );
        logic [PHY_AW-1:0] ps;
        logic [REG_AW-1:0] rs;
        logic [DATA_W-1:0] ws;
        ps = pa << (s - L_PHY);
        rs = ra << (s - L_REG);
        ws = wd << (s - L_WDAT);
        if (s < L_START)                  return 2'b11;
        else if (s == L_START)            return 2'b10;
        else if (s == L_ST1)              return 2'b11;
        else if (s == L_OP)               return {1'b1, rd};
        else if (s == L_OP1)              return {1'b1, !rd};
        else if (s < L_REG)               return {1'b1, ps[PHY_AW-1]};
        else if (s < L_TA)                return {1'b1, rs[REG_AW-1]};
        else if (rd)                      return 2'b00;
        else if (s == L_TA)               return 2'b11;
        else if (s == L_TA1)              return 2'b10;
        else if (s >= L_WDAT && s <= L_WEND) return {1'b1, ws[DATA_W-1]};
        else                              return 2'b00;
    endfunction

    // Slot-end decisions, taken at the tick that closes a high half.
    always_comb begin
        ta_fail = (state_q == ST_FRAME) && rd_q && (slot_q == L_TA) && mdio_in_i;
        cap_en  = (state_q == ST_FRAME) && rd_q && (slot_q >= L_RDAT) && (slot_q <= L_REND);
        end_ok  = (state_q == ST_FRAME) && (slot_q == L_LAST);
        end_err = (state_q == ST_RECOVER) && (slot_q == L_RLAST);
    end

    // Frame sequencer: accepts requests, steps slots, drives the pins, captures data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            hi_q    <= 1'b0;
            rd_q    <= 1'b0;
            phy_q   <= '0;
            reg_q   <= '0;
            wd_q    <= '0;
            shift_q <= '0;
            rdata_q <= '0;
            mdc_q   <= 1'b1;
            dq      <= 1'b0;
            oe_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (start_i) begin
                    rd_q    <= rd_i;
                    phy_q   <= phy_i;
                    reg_q   <= reg_i;
                    wd_q    <= wd_i;
                    state_q <= ST_FRAME;
                    slot_q  <= '0;
                    hi_q    <= 1'b0;
                    mdc_q   <= 1'b0;
                    {oe_q, dq} <= slot_drive('0, rd_i, phy_i, reg_i, wd_i);
                end
            end else if (tick_i) begin
                if (!hi_q) begin
                    hi_q  <= 1'b1;
                    mdc_q <= 1'b1;
                end else if (end_ok || end_err) begin
                    state_q <= ST_IDLE;
                    hi_q    <= 1'b0;
                    oe_q    <= 1'b0;
                    done_q  <= 1'b1;
                    err_q   <= end_err;
                    if (end_ok && rd_q) rdata_q <= shift_q;
                end else begin
                    hi_q   <= 1'b0;
                    mdc_q  <= 1'b0;
                    slot_q <= slot_q + 1'b1;
                    if (ta_fail) state_q <= ST_RECOVER;
                    if (cap_en) shift_q <= {shift_q[DATA_W-2:0], mdio_in_i};
                    if (state_q == ST_RECOVER) {oe_q, dq} <= 2'b00;
                    else {oe_q, dq} <= slot_drive(slot_q + 1'b1, rd_q, phy_q, reg_q, wd_q);
                end
            end
        end
    end

    assign run_o     = (state_q != ST_IDLE);
    assign mdc_o     = mdc_q;
    assign mdio_o    = dq;
    assign mdio_oe_o = oe_q;
    assign rd_data_o = rdata_q;
    assign done_o    = done_q;
    assign err_o     = err_q;

    // The line never changes across a high half of MDC.
    assert_line_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_q && $past(mdc_q)) |-> ($stable(dq) && $stable(oe_q)));

    // Preamble slots drive a one.
    assert_preamble_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FRAME && slot_q < L_START) |-> (oe_q && dq));

    // Reads never drive from turnaround onward.
    assert_read_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && rd_q && slot_q >= L_TA) |-> !oe_q);

    // A failed turnaround can only follow a read.
    assert_recover_read_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER) |-> rd_q);

    // A strobe during a frame leaves the latched request alone.
    assert_busy_request_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=>
            (rd_q == $past(rd_q) && phy_q == $past(phy_q) && reg_q == $past(reg_q)
             && wd_q == $past(wd_q)));

    // Done is a single-cycle pulse.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // Error appears only alongside done.
    assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> done_q);

    // In the done cycle the bus is already parked.
    assert_parked_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (mdc_q && !oe_q));

endmodule

// File: rtl/mdio_frame_master.sv
// Module: mdio_frame_master (top)
// Single-transaction management bus master. It ties the half-period
// tick generator to the frame sequencer and synchronises the returning
// line. Assumes an external pull-up on the line, an external buffer
// that uses mdio_oe_o, and HALF_CYCLES >= 3 so that the two-flop
// synchroniser settles inside an MDC high half.
module mdio_frame_master #(
    parameter int HALF_CYCLES = 40,
    parameter int PRE_LEN     = 32,
    parameter int RECOV_LEN   = 32,
    parameter int PHY_AW      = 5,
    parameter int REG_AW      = 5,
    parameter int DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              rd_nwr_i,
    input  logic [PHY_AW-1:0] phy_addr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o,
    output logic              err_o,
    output logic              mdc_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic              mdio_i
);
    logic       run, tick;
    logic [1:0] sync_q;

    // Two-flop synchroniser for the bus line; resets to the pulled-up level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], mdio_i};
    end

    mdc_tick_gen #(
        .HALF_CYCLES(HALF_CYCLES)
    ) tick_i0 (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (run),
        .tick_o(tick)
    );

    mdio_frame_seq #(
        .PRE_LEN  (PRE_LEN),
        .RECOV_LEN(RECOV_LEN),
        .PHY_AW   (PHY_AW),
        .REG_AW   (REG_AW),
        .DATA_W   (DATA_W)
    ) seq_i0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .start_i  (start_i),
        .rd_i     (rd_nwr_i),
        .phy_i    (phy_addr_i),
        .reg_i    (reg_addr_i),
        .wd_i     (wr_data_i),
        .mdio_in_i(sync_q[1]),
        .run_o    (run),
        .mdc_o    (mdc_o),
        .mdio_o   (mdio_o),
        .mdio_oe_o(mdio_oe_o),
        .rd_data_o(rd_data_o),
        .done_o   (done_o),
        .err_o    (err_o)
    );

    // MDC stays high whenever no frame is running.
    assert_idle_mdc_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (mdc_o && !mdio_oe_o));

endmodule

// File: tb/mdio_frame_master_tb.sv
// Scoreboard bench: the driver queues expected transactions, a PHY model
// answers reads, and the monitor decodes MDC rising edges and checks
// each frame when done_o appears.
module mdio_frame_master_tb_top;
    localparam int H       = 4;
    localparam int TA_SLOT = 46;
    localparam int RD_DAT  = 47;
    localparam int WR_DAT  = 48;
    localparam int LEN_OK  = 65;
    localparam int LEN_ERR = 79;

    typedef struct {
        bit        rd;
        bit [4:0]  pa;
        bit [4:0]  ra;
        bit [15:0] wd;
        bit [15:0] rdat;
        bit        fail;
    } item_t;

    logic clk = 1'b0;
    logic rst_n, start, rd_nwr;
    logic [4:0] pa, ra;
    logic [15:0] wd;
    logic [15:0] rd_data;
    logic done, err, mdc, mdio_o, mdio_oe, mdio_line;
    logic phy_en, phy_bit;

    item_t sb_q[$];
    int n_chk = 0, n_fail = 0, done_cnt = 0, cyc = 0;
    bit [15:0] last_good;

    always #2.5 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

    mdio_frame_master #(.HALF_CYCLES(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rd_nwr_i(rd_nwr),
        .phy_addr_i(pa), .reg_addr_i(ra), .wr_data_i(wd),
        .rd_data_o(rd_data), .done_o(done), .err_o(err),
        .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_line)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor / PHY model state
    logic       mdc_prev, done_prev, in_frame, bad_period, contention;
    int         nrise, run_len;
    logic       rv[0:127];
    logic       ro[0:127];

    task automatic judge_frame();
        item_t it;
        int    len;
        bit    ok;
        logic  ev, eo;
        if (sb_q.size() == 0) begin
            check(1'b0, "R9", "unexpected done", 1, 0);
            return;
        end
        it  = sb_q.pop_front();
        len = (it.rd && it.fail) ? LEN_ERR : LEN_OK;
        check(nrise == len, it.rd ? (it.fail ? "R8" : "R7") : "R6", "mdc cycles", nrise, len);
        ok = 1;
        for (int k = 0; k < 32; k++) if (!(ro[k] && rv[k])) ok = 0;
        check(ok, "R2", "preamble", 0, 1);
        ok = ro[32] && !rv[32] && ro[33] && rv[33] && ro[34] && (rv[34] == it.rd)
             && ro[35] && (rv[35] == !it.rd);
        check(ok, "R3", "start/opcode", {rv[32], rv[33], rv[34], rv[35]},
              {2'b01, it.rd, !it.rd});
        ok = 1;
        for (int k = 0; k < 5; k++) begin
            if (!(ro[36+k] && rv[36+k] == it.pa[4-k])) ok = 0;
            if (!(ro[41+k] && rv[41+k] == it.ra[4-k])) ok = 0;
        end
        check(ok, "R4", "addresses", 0, {it.pa, it.ra});
        ok = 1;
        for (int k = TA_SLOT; k < len && k < 128; k++) begin
            if (it.rd) begin
                eo = 1'b0; ev = 1'b0;
            end else if (k == TA_SLOT) begin
                eo = 1'b1; ev = 1'b1;
            end else if (k == TA_SLOT + 1) begin
                eo = 1'b1; ev = 1'b0;
            end else if (k >= WR_DAT && k < WR_DAT + 16) begin
                eo = 1'b1; ev = it.wd[15-(k-WR_DAT)];
            end else begin
                eo = 1'b0; ev = 1'b0;
            end
            if (ro[k] != eo || (eo && rv[k] != ev)) ok = 0;
        end
        check(ok, it.rd ? "R7" : "R6", "turnaround/data phase", 0, it.wd);
        check(!bad_period, "R5", "half period length", bad_period, 0);
        check(!contention, "R7", "bus contention", contention, 0);
        check(mdc && !mdio_oe, "R1", "parked at done", {mdc, mdio_oe}, 2'b10);
        check(err == (it.rd && it.fail), it.fail ? "R8" : "R10", "err flag", err,
              it.rd && it.fail);
        if (it.rd && !it.fail) begin
            check(rd_data == it.rdat, "R7", "read data", rd_data, it.rdat);
            last_good = it.rdat;
        end else if (it.rd) begin
            check(rd_data == last_good, "R8", "read data kept", rd_data, last_good);
        end
    endtask

    // Monitor, PHY responder and period checker, sampled between edges.
    always @(negedge clk) begin
        if (!rst_n) begin
            mdc_prev = mdc; done_prev = 1'b0; in_frame = 1'b0; nrise = 0;
            run_len = 1; bad_period = 1'b0; contention = 1'b0;
            phy_en = 1'b0; phy_bit = 1'b1; last_good = '0;
        end else begin
            if (done && done_prev) check(1'b0, "R10", "done wider than one cycle", 1, 0);
            if (mdio_oe && phy_en) contention = 1'b1;
            if (mdc != mdc_prev) begin
                if (in_frame && run_len != H) bad_period = 1'b1;
                run_len = 1;
                if (!mdc) begin
                    in_frame = 1'b1;
                    phy_en = 1'b0; phy_bit = 1'b1;
                    if (sb_q.size() != 0 && sb_q[0].rd && !sb_q[0].fail) begin
                        if (nrise == TA_SLOT) begin
                            phy_en = 1'b1; phy_bit = 1'b0;
                        end else if (nrise >= RD_DAT && nrise < RD_DAT + 16) begin
                            phy_en = 1'b1; phy_bit = sb_q[0].rdat[15-(nrise-RD_DAT)];
                        end
                    end
                end else begin
                    if (nrise < 128) begin
                        rv[nrise] = mdio_o; ro[nrise] = mdio_oe;
                    end
                    nrise++;
                end
            end else begin
                run_len++;
            end
            if (done) begin
                judge_frame();
                done_cnt++;
                nrise = 0; in_frame = 1'b0; bad_period = 1'b0; contention = 1'b0;
                phy_en = 1'b0;
            end
            mdc_prev = mdc;
            done_prev = done;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic issue(input bit r, input bit [4:0] p, input bit [4:0] g,
                         input bit [15:0] w, input bit [15:0] rdat, input bit f);
        item_t it;
        it.rd = r; it.pa = p; it.ra = g; it.wd = w; it.rdat = rdat; it.fail = f;
        @(negedge clk);
        sb_q.push_back(it);
        rd_nwr = r; pa = p; ra = g; wd = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int c0 = done_cnt;
        while (done_cnt == c0) @(negedge clk);
    endtask

    task automatic txn(input bit r, input bit [4:0] p, input bit [4:0] g,
                       input bit [15:0] w, input bit [15:0] rdat, input bit f);
        issue(r, p, g, w, rdat, f);
        wait_done();
        repeat (5) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; rd_nwr = 1'b0; pa = '0; ra = '0; wd = '0;
        repeat (3) @(negedge clk);
        check(mdc && !mdio_oe && !done && rd_data == 16'h0, "R11", "reset state",
              {mdc, mdio_oe, done}, 3'b100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        txn(1'b0, 5'h1F, 5'h00, 16'h8001, 16'h0, 1'b0);   // R6 write
        txn(1'b0, 5'h00, 5'h1F, 16'h0000, 16'h0, 1'b0);   // R6 write zeros
        txn(1'b1, 5'h15, 5'h0A, 16'h0, 16'hA5C3, 1'b0);   // R7 read
        txn(1'b1, 5'h01, 5'h02, 16'h0, 16'hFFFF, 1'b0);   // R7 all ones
        txn(1'b1, 5'h0A, 5'h15, 16'h0, 16'h0, 1'b1);      // R8 no turnaround
        txn(1'b1, 5'h1E, 5'h01, 16'h0, 16'h0001, 1'b0);   // R7 after error

        // R9: strobe with a different request in mid-frame
        issue(1'b0, 5'h12, 5'h07, 16'h3C5A, 16'h0, 1'b0);
        repeat (200) @(negedge clk);
        rd_nwr = 1'b1; pa = 5'h03; ra = 5'h1C; wd = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (100) @(negedge clk);
        check(mdc && !mdio_oe && nrise == 0, "R9", "no frame after ignored strobe",
              {mdc, mdio_oe}, 2'b10);

        // R11: reset in mid-frame
        issue(1'b1, 5'h04, 5'h05, 16'h0, 16'h1234, 1'b0);
        repeat (300) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(mdc && !mdio_oe && !done, "R11", "mid-frame reset parks bus",
              {mdc, mdio_oe, done}, 3'b100);
        check(rd_data == 16'h0, "R11", "read data cleared", rd_data, 0);
        sb_q.delete();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        txn(1'b1, 5'h07, 5'h11, 16'h0, 16'h6E2B, 1'b0);   // R7 after reset
        txn(1'b0, 5'h10, 5'h08, 16'hC0DE, 16'h0, 1'b0);   // R6 after reset

        check(sb_q.size() == 0, "R10", "all queued transactions completed",
              sb_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule